// File: doc/BRIEF.md
# Colour Palette Loader and Lookup

This block owns the colour lookup table of a display path that shows indexed-colour pixels. It takes 16-bit words from an incoming stream with valid/ready flow control. The sequencing depends on a 2-bit load-mode selection that is latched when the block is enabled. In palette-only mode the block accepts one palette and then stops. In frame-only mode it treats every word as a pixel. In palette-then-frame mode it loads a palette first and then switches to pixels. The first palette word is a header. Its top nibble gives the pixel depth, and its low 12 bits become table entry 0.

Pixels arrive either as frame-phase stream words or on a side lookup port. Each pixel is translated into a 12-bit red/green/blue colour one cycle later. At indexed depths the colour is read from the table. At the direct-colour depths the low 12 bits of the pixel value pass through unchanged. A status flag reports that a complete palette has arrived. How that flag may be cleared depends on the load mode.

Top module: `palette_lut`

## Requirements
- R1: While reset is active and after it is released, in_ready, loaded, rgb_valid, rgb and bpp_code are all zero.
- R2: The load mode is latched on the first enabled cycle, and the matching phase starts on the next cycle. 2'b01 and 2'b00 start a palette phase. 2'b10 starts a frame phase. 2'b11 accepts no words at all. in_ready is high only during a palette or frame phase, and it is low on every cycle that follows a cycle with enable low.
- R3: Bits 15:12 of the first palette word are stored as bpp_code. Codes 0 to 3 (1, 2, 4 and 8 bits per pixel) make the palette 256 words long. Codes of 4 and above (12 or 16 bits per pixel) make it 16 words long.
- R4: The n-th accepted palette word (header is n=0) is stored as entry n from its bits 11:0, laid out as red 11:8, green 7:4 and blue 3:0. Bits 15:12 of the other words are ignored.
- R5: loaded rises on the cycle after the last palette word is accepted. Mode 2'b01 then drops in_ready and accepts nothing more. Mode 2'b00 moves to the frame phase.
- R6: clr_loaded clears loaded only when the latched mode is 2'b01. A clear in any other mode has no effect. Disabling the block clears loaded in every mode.
- R7: At indexed depths, a pixel value v presented on a cycle gives rgb_valid high and rgb equal to entry v on the next cycle. Any value above 255 gives rgb 0.
- R8: At bpp_code 4 or above, rgb equals bits 11:0 of the pixel value.
- R9: A stream word accepted in the frame phase is the pixel for that cycle. pix_valid and pix_in are ignored on that cycle.
- R10: Palette contents and bpp_code survive a disable. A later frame-only run uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low returns to idle |
| load_mode | input | 2 | Sequencing selection, latched at start |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 16 | Stream word |
| in_ready | output | 1 | Stream word accepted when high with in_valid |
| clr_loaded | input | 1 | Request to clear the loaded flag |
| pix_valid | input | 1 | Side-port pixel valid |
| pix_in | input | 16 | Side-port pixel value |
| rgb_valid | output | 1 | Colour output valid |
| rgb | output | 12 | Colour, red 11:8, green 7:4, blue 3:0 |
| loaded | output | 1 | Complete palette received |
| bpp_code | output | 4 | Depth code from the last palette header |

## Verification
The bench uses the default parameters: an 8-bit index (256 entries) and a 16-entry short palette. With these values a full long palette and a full short palette are short enough to stream completely. That lets the runs reach the exact last-entry boundary in both lengths, and the 255/256 edge of the index range. A behavioural model is compared with the outputs on every cycle while the runs step through all four load modes, clears in the allowed and ignored modes, and a frame-only run that reuses a palette stored earlier.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int IDX_W   = 8,
  parameter int SMALL_N = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  load_mode,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  input  logic        clr_loaded,
  input  logic        pix_valid,
  input  logic [15:0] pix_in,
  output logic        rgb_valid,
  output logic [11:0] rgb,
  output logic        loaded,
  output logic [3:0]  bpp_code
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [3:0] DIRECT_C = 4'd4;
  localparam logic [1:0] LM_BOTH = 2'b00, LM_PAL = 2'b01, LM_FRAME = 2'b10, LM_NONE = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_PAL, ST_FRAME, ST_HOLD} st_t;

  st_t              state;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] cnt;
  logic [11:0]      mem [ENTRIES];

  assign in_ready = (state == ST_PAL) || (state == ST_FRAME);

  wire take     = in_valid && in_ready;
  wire pal_take = take && (state == ST_PAL);
  wire frm_take = take && (state == ST_FRAME);

  wire [3:0]       code_now = (cnt == '0) ? in_data[15:12] : bpp_code;
  wire [IDX_W-1:0] last_idx = (code_now >= DIRECT_C) ? IDX_W'(SMALL_N - 1) : IDX_W'(ENTRIES - 1);
  wire             pal_last = pal_take && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= LM_BOTH;
      cnt      <= '0;
      loaded   <= 1'b0;
      bpp_code <= '0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      loaded <= 1'b0;
    end else begin
      if (clr_loaded && mode_q == LM_PAL) loaded <= 1'b0;
      case (state)
        ST_IDLE: begin
          mode_q <= load_mode;
          cnt    <= '0;
          if (load_mode == LM_FRAME)     state <= ST_FRAME;
          else if (load_mode == LM_NONE) state <= ST_HOLD;
          else                           state <= ST_PAL;
        end
        ST_PAL: if (pal_take) begin
          if (cnt == '0) bpp_code <= in_data[15:12];
          if (pal_last) begin
            loaded <= 1'b1;
            state  <= (mode_q == LM_BOTH) ? ST_FRAME : ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pal_take) mem[cnt] <= in_data[11:0];
  end

  wire [15:0] src      = frm_take ? in_data : pix_in;
  wire        src_v    = frm_take || pix_valid;
  wire        direct   = bpp_code >= DIRECT_C;
  wire        in_range = (src >> IDX_W) == 16'd0;
  wire [11:0] rgb_d    = direct ? src[11:0] : (in_range ? mem[src[IDX_W-1:0]] : 12'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      rgb_valid <= src_v;
      rgb       <= rgb_d;
    end
  end

  // R2
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !in_ready);

  // R5
  loaded_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(state) == ST_PAL);

  // R5
  pal_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) && mode_q == LM_PAL |-> !in_ready);

  // R6
  keep_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded && enable && mode_q != LM_PAL |=> loaded);

  // R6
  drop_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !loaded);

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_v && !direct && !in_range |=> rgb == 12'd0);
endmodule

// File: tb/test_palette_lut.sv
`timescale 1ns/1ps
module test_palette_lut;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [1:0]  load_mode = 0;
  logic        in_valid = 0;
  logic [15:0] in_data = 0;
  logic        in_ready;
  logic        clr_loaded = 0;
  logic        pix_valid = 0;
  logic [15:0] pix_in = 0;
  logic        rgb_valid;
  logic [11:0] rgb;
  logic        loaded;
  logic [3:0]  bpp_code;

  int checks = 0, fails = 0, cyc = 0;

  palette_lut i_palette_lut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_mode(load_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .clr_loaded(clr_loaded), .pix_valid(pix_valid), .pix_in(pix_in),
    .rgb_valid(rgb_valid), .rgb(rgb), .loaded(loaded), .bpp_code(bpp_code)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pat(input int sel, input int i);
    return sel ? ((i * 29 + 3) & 12'hfff) : ((i * 73 + 11) & 12'hfff);
  endfunction

  // behavioural reference model: phase 0 idle, 1 palette, 2 frame, 3 hold
  int m_ph, m_mode, m_cnt, m_loaded, m_bpp, m_rv, m_rgb;
  int pal [256];

  function automatic int m_look(input int v);
    if (m_bpp >= 4) return v & 12'hfff;
    if (v > 255) return 0;
    return pal[v];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_cnt = 0; m_loaded = 0; m_bpp = 0; m_rv = 0; m_rgb = 0;
    end else begin
      bit rdy, fr, pt, setl;
      int size;
      rdy = (m_ph == 1 || m_ph == 2);
      fr  = (m_ph == 2) && in_valid;
      pt  = (m_ph == 1) && in_valid;
      m_rv = fr || pix_valid;
      m_rgb = m_look(fr ? int'(in_data) : int'(pix_in));
      setl = 0;
      if (!enable) begin
        m_ph = 0; m_loaded = 0;
      end else begin
        if (m_ph == 0) begin
          m_mode = load_mode; m_cnt = 0;
          m_ph = (load_mode == 2) ? 2 : (load_mode == 3) ? 3 : 1;
        end else if (pt) begin
          if (m_cnt == 0) m_bpp = in_data[15:12];
          pal[m_cnt] = in_data[11:0];
          size = (m_bpp >= 4) ? 16 : 256;
          if (m_cnt == size - 1) begin
            setl = 1;
            m_ph = (m_mode == 0) ? 2 : 3;
          end else m_cnt++;
        end
        if (clr_loaded && m_mode == 1 && !setl) m_loaded = 0;
        if (setl) m_loaded = 1;
      end
      if (rdy) ;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == (m_ph == 1 || m_ph == 2), "R2 in_ready vs model", in_ready, (m_ph == 1 || m_ph == 2));
      chk(loaded == m_loaded[0], "R5 loaded vs model", loaded, m_loaded);
      chk(bpp_code == m_bpp[3:0], "R3 bpp_code vs model", bpp_code, m_bpp);
      chk(rgb_valid == m_rv[0], "R7 rgb_valid vs model", rgb_valid, m_rv);
      if (m_rv != 0) chk(rgb == m_rgb[11:0], "R7 rgb vs model", rgb, m_rgb);
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic send(input logic [15:0] w);
    logic r;
    in_valid = 1; in_data = w;
    do begin r = in_ready; @(negedge clk); end while (!r);
    in_valid = 0;
  endtask

  task automatic load(input int code, input int n, input int sel);
    for (int i = 0; i < n; i++) begin
      send(i == 0 ? {code[3:0], pat(sel, 0)[11:0]} : {4'h9, pat(sel, i)[11:0]});
      if (i % 5 == 3) @(negedge clk);
    end
  endtask

  task automatic look(input logic [15:0] v, input int exp, input string tag);
    pix_valid = 1; pix_in = v;
    @(negedge clk);
    pix_valid = 0;
    chk(rgb_valid && rgb == exp[11:0], tag, rgb, exp);
  endtask

  task automatic frame_look(input logic [15:0] v, input int exp, input string tag);
    in_valid = 1; in_data = v;
    @(negedge clk);
    in_valid = 0;
    chk(rgb_valid && rgb == exp[11:0], tag, rgb, exp);
  endtask

  task automatic start(input logic [1:0] m);
    enable = 1; load_mode = m;
    @(negedge clk);
  endtask

  task automatic stop;
    enable = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !loaded && !rgb_valid && rgb == 0 && bpp_code == 0, "R1 reset outputs",
        {in_ready, loaded, rgb_valid, bpp_code}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready && !loaded && !rgb_valid && bpp_code == 0, "R1 after release", {in_ready, loaded, rgb_valid}, 0);

    // mode 11: nothing accepted
    start(2'b11);
    in_valid = 1; in_data = 16'h3123;
    for (int k = 0; k < 3; k++) begin
      chk(!in_ready, "R2 mode 11 refuses words", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0;
    stop();

    // palette only, short palette (direct depth)
    start(2'b01);
    chk(in_ready, "R2 palette phase ready", in_ready, 1);
    load(4, 16, 0);
    chk(!in_ready && loaded, "R5 palette-only stops after 16 words", {in_ready, loaded}, 1);
    chk(bpp_code == 4, "R3 header code captured", bpp_code, 4);
    look(16'hABCD, 12'hBCD, "R8 direct passthrough");
    look(16'h0FFF, 12'hFFF, "R8 direct passthrough max");
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(!loaded, "R6 clear in palette-only mode", loaded, 0);
    stop();

    // palette then frame, long palette
    start(2'b00);
    load(3, 256, 1);
    chk(in_ready && loaded, "R5 frame phase follows palette", {in_ready, loaded}, 3);
    chk(bpp_code == 3, "R3 indexed code", bpp_code, 3);
    look(16'd0, pat(1, 0), "R4 header is entry 0");
    look(16'd5, pat(1, 5), "R4 entry 5");
    look(16'd255, pat(1, 255), "R7 top index");
    look(16'd256, 0, "R7 index 256 invalid");
    look(16'd1000, 0, "R7 large index invalid");
    frame_look(16'd7, pat(1, 7), "R7 frame word lookup");
    pix_valid = 1; pix_in = 16'd9;
    frame_look(16'd12, pat(1, 12), "R9 frame word wins over side port");
    pix_valid = 0;
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(loaded, "R6 clear ignored in mode 00", loaded, 1);
    stop();
    chk(!loaded, "R6 disable clears loaded", loaded, 0);

    // frame only reuses stored palette
    start(2'b10);
    chk(in_ready && !loaded, "R2 frame-only phase", {in_ready, loaded}, 2);
    chk(bpp_code == 3, "R10 depth code kept", bpp_code, 3);
    frame_look(16'd200, pat(1, 200), "R10 retained entry 200");
    frame_look(16'd1, pat(1, 1), "R10 retained entry 1");
    clr_loaded = 1; @(negedge clk); clr_loaded = 0;
    chk(!loaded && in_ready, "R6 clear in frame-only has no effect", {loaded, in_ready}, 1);
    stop();

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule